// File: doc/BRIEF.md
# DMA Launch Register Frontend

This block is the configuration face of a multi-dimensional DMA engine. Software programs a small transfer descriptor (source address, destination address, length) over APB4. It then starts a transfer by reading a per-stream "launch" register. That read completes at once and returns the identifier the new transfer will carry. A copy of the descriptor, tagged with that identifier and the stream number, is parked in a per-stream slot. From there it is handed to the backend through a valid/ready handshake. Software tracks progress by polling a per-stream "finished" register. That register holds the identifier of the most recently completed transfer.

Several APB ports share the frontend. A round-robin arbiter picks one port to serve in each cycle. A second round-robin arbiter picks among the per-stream slots for the single backend request output. The frontend owns both identifier counters for every stream: the next identifier to issue, and the last one completed. Both wrap modulo a parameterized width.

Top module: `dma_launch_fe`

## Requirements
- R1: After reset, `launch_valid` is low and every stream's finished register (byte address 0x200 + 4*stream) reads 1.
- R2: A read of a stream's launch register (byte address 0x100 + 4*stream) completes in its first ACCESS cycle (PREADY high, no wait states) when no launch of that stream is outstanding, even while `launch_ready` is low.
- R3: Each completed launch-register read produces exactly one backend request. That request carries the stream, the identifier returned by the read, and the descriptor fields as they stood at the read.
- R4: While `launch_valid` is high and `launch_ready` is low, `launch_valid` stays high and the stream, identifier and descriptor outputs hold their values.
- R5: A stream's issue counter starts at 2 and advances by one per accepted request, so successive launch reads on a stream return consecutive identifiers.
- R6: A launch read on a stream whose previous launch is still held (pending or not yet accepted) is stalled with PREADY low. It completes only after that launch is accepted, and returns the following identifier. The held launch is never overwritten.
- R7: A completion pulse for a stream advances its finished register by one. A completion for a stream with no accepted-but-unfinished transfer (finished = issued − 1, modulo the width) is ignored.
- R8: Descriptor words at 0x0 (source), 0x4 (destination) and 0x8 (length) are written in the completing ACCESS cycle. Each of the 4 strobe bits enables one byte lane (bit n covers data bits 8n+7..8n). The words read back as stored and reset to 0.
- R9: An access to an unmapped or misaligned address, or a write to a launch or finished register, completes with PSLVERR high. It changes no descriptor word and starts no launch.
- R10: When two ports present accesses in the same cycle, both are served, one per cycle, in round-robin order, and launches from both reach the backend.
- R11: Identifiers wrap modulo 2^ID_W: after issuing 2^ID_W − 1 the next launch read returns 0, and completion tracking continues across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | NUM_PORTS | APB select, one bit per port |
| penable | input | NUM_PORTS | APB enable, one bit per port |
| pwrite | input | NUM_PORTS | APB write flag, one bit per port |
| paddr | input | 32*NUM_PORTS | APB byte addresses, port p in bits 32p+31..32p |
| pwdata | input | 32*NUM_PORTS | APB write data, port p in bits 32p+31..32p |
| pstrb | input | 4*NUM_PORTS | APB byte strobes, port p in bits 4p+3..4p |
| pready | output | NUM_PORTS | APB ready, one bit per port |
| pslverr | output | NUM_PORTS | APB error response, one bit per port |
| prdata | output | 32*NUM_PORTS | APB read data, port p in bits 32p+31..32p |
| launch_valid | output | 1 | Backend request valid |
| launch_ready | input | 1 | Backend accepts the request |
| launch_stream | output | SW | Stream of the request |
| launch_id | output | ID_W | Transfer identifier of the request |
| launch_src | output | 32 | Source address of the request |
| launch_dst | output | 32 | Destination address of the request |
| launch_len | output | 32 | Length of the request |
| cmpl_valid | input | 1 | Backend completion pulse |
| cmpl_stream | input | SW | Stream of the completion |

## Verification
The hardest situation to reach is a second launch read that collides with a launch still held at the backend boundary. It is the only path where the slot could be overwritten or the returned identifier could run ahead of the issue counter. The stimulus holds `launch_ready` low, completes one launch read, and starts a second read on the same stream in a parallel thread. It keeps backpressure for several cycles, then releases it. The bench then expects a stall of at least that length, the older request first, and the next identifier for the stalled read. The counter wrap is reached by shrinking the identifier width to 4 bits in the bench and looping launches and completions past the wrap.

// File: rtl/dma_launch_pkg.sv
package dma_launch_pkg;

  // byte addresses of the register file
  localparam logic [31:0] OFS_SRC   = 32'h0000_0000;
  localparam logic [31:0] OFS_DST   = 32'h0000_0004;
  localparam logic [31:0] OFS_LEN   = 32'h0000_0008;
  localparam logic [31:0] NEXT_BASE = 32'h0000_0100;
  localparam logic [31:0] DONE_BASE = 32'h0000_0200;

  typedef struct packed {
    logic [31:0] src;
    logic [31:0] dst;
    logic [31:0] len;
  } desc_t;

  function automatic logic [31:0] merge_bytes(input logic [31:0] cur,
                                              input logic [31:0] nw,
                                              input logic [3:0]  en);
    logic [31:0] r;
    r = cur;
    for (int b = 0; b < 4; b++) begin
      if (en[b]) r[b*8 +: 8] = nw[b*8 +: 8];
    end
    return r;
  endfunction

endpackage

// File: rtl/fe_rr_arb.sv
module fe_rr_arb #(
  parameter  int unsigned N  = 2,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  input  logic          adv,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] sel,
  output logic          any
);

  logic [IW-1:0] last_q;

  // first requester above the last winner, else the lowest one at or below it
  always_comb begin
    gnt = '0;
    sel = '0;
    any = 1'b0;
    for (int i = 0; i < int'(N); i++) begin
      if (!any && req[i] && (IW'(i) > last_q)) begin
        any = 1'b1;
        sel = IW'(i);
        gnt[i] = 1'b1;
      end
    end
    for (int i = 0; i < int'(N); i++) begin
      if (!any && req[i] && (IW'(i) <= last_q)) begin
        any = 1'b1;
        sel = IW'(i);
        gnt[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              last_q <= IW'(N - 1);
    else if (adv && any)  last_q <= sel;
  end

endmodule

// File: rtl/fe_id_counters.sv
module fe_id_counters #(
  parameter  int unsigned NS   = 4,
  parameter  int unsigned ID_W = 32,
  localparam int unsigned SW   = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     acc_v,
  input  logic [SW-1:0]            acc_s,
  input  logic                     cmpl_v,
  input  logic [SW-1:0]            cmpl_s,
  output logic [NS-1:0][ID_W-1:0]  issued_o,
  output logic [NS-1:0][ID_W-1:0]  done_o
);

  for (genvar s = 0; s < NS; s++) begin : g_cnt
    logic [ID_W-1:0] iss_q;
    logic [ID_W-1:0] dn_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        iss_q <= ID_W'(2);
        dn_q  <= ID_W'(1);
      end else begin
        if (acc_v && (acc_s == SW'(s))) iss_q <= iss_q + 1'b1;
        // wrap-aware: only advance while something is outstanding
        if (cmpl_v && (cmpl_s == SW'(s)) && ((iss_q - dn_q) != ID_W'(1)))
          dn_q <= dn_q + 1'b1;
      end
    end

    assign issued_o[s] = iss_q;
    assign done_o[s]   = dn_q;
  end

endmodule

// File: rtl/dma_launch_fe.sv
module dma_launch_fe
  import dma_launch_pkg::*;
#(
  parameter  int unsigned NUM_PORTS   = 2,
  parameter  int unsigned NUM_STREAMS = 4,
  parameter  int unsigned ID_W        = 32,
  localparam int unsigned SW  = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1,
  localparam int unsigned PIW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_PORTS-1:0]     psel,
  input  logic [NUM_PORTS-1:0]     penable,
  input  logic [NUM_PORTS-1:0]     pwrite,
  input  logic [NUM_PORTS*32-1:0]  paddr,
  input  logic [NUM_PORTS*32-1:0]  pwdata,
  input  logic [NUM_PORTS*4-1:0]   pstrb,
  output logic [NUM_PORTS-1:0]     pready,
  output logic [NUM_PORTS-1:0]     pslverr,
  output logic [NUM_PORTS*32-1:0]  prdata,
  output logic                     launch_valid,
  input  logic                     launch_ready,
  output logic [SW-1:0]            launch_stream,
  output logic [ID_W-1:0]          launch_id,
  output logic [31:0]              launch_src,
  output logic [31:0]              launch_dst,
  output logic [31:0]              launch_len,
  input  logic                     cmpl_valid,
  input  logic [SW-1:0]            cmpl_stream
);

  // ---------------- port arbitration ----------------
  logic [NUM_PORTS-1:0] p_gnt;
  logic [PIW-1:0]       p_sel;
  logic                 g_any;

  fe_rr_arb #(.N(NUM_PORTS)) u_port_arb (
    .clk (clk), .rst (rst), .req (psel & penable), .adv (1'b1),
    .gnt (p_gnt), .sel (p_sel), .any (g_any)
  );

  logic [31:0] g_addr, g_wdata;
  logic [3:0]  g_strb;
  logic        g_write;

  always_comb begin
    g_addr  = paddr[32*p_sel +: 32];
    g_wdata = pwdata[32*p_sel +: 32];
    g_strb  = pstrb[4*p_sel +: 4];
    g_write = pwrite[p_sel];
  end

  // ---------------- decode ----------------
  logic [31:0]     nxt_off, dn_off;
  logic            is_src, is_dst, is_len, nxt_hit, dn_hit;
  logic [SW-1:0]   nxt_s, dn_s;

  assign nxt_off = g_addr - NEXT_BASE;
  assign dn_off  = g_addr - DONE_BASE;
  assign is_src  = (g_addr == OFS_SRC);
  assign is_dst  = (g_addr == OFS_DST);
  assign is_len  = (g_addr == OFS_LEN);
  assign nxt_hit = (nxt_off[31:2] < 30'(NUM_STREAMS)) && (nxt_off[1:0] == 2'b00);
  assign dn_hit  = (dn_off[31:2]  < 30'(NUM_STREAMS)) && (dn_off[1:0]  == 2'b00);
  assign nxt_s   = nxt_off[SW+1:2];
  assign dn_s    = dn_off[SW+1:2];

  // ---------------- state ----------------
  desc_t                                desc_q;
  logic [NUM_STREAMS-1:0]               pend_v;
  desc_t                                pend_d  [NUM_STREAMS];
  logic [ID_W-1:0]                      pend_id [NUM_STREAMS];
  logic                                 out_v;
  logic [SW-1:0]                        out_s;
  desc_t                                out_d;
  logic [ID_W-1:0]                      out_id;
  logic [NUM_STREAMS-1:0][ID_W-1:0]     issued_q, done_q;
  logic [NUM_STREAMS-1:0]               busy;

  always_comb begin
    for (int s = 0; s < int'(NUM_STREAMS); s++)
      busy[s] = pend_v[s] | (out_v && (out_s == SW'(s)));
  end

  logic err, rd_next, stall, fire, wr_ok;
  logic [31:0] rd;
  logic [NUM_STREAMS-1:0] set_vec;

  assign err     = g_any && !(is_src || is_dst || is_len ||
                              (!g_write && (nxt_hit || dn_hit)));
  assign rd_next = g_any && !g_write && nxt_hit;
  assign stall   = rd_next && busy[nxt_s];
  assign fire    = rd_next && !busy[nxt_s];
  assign wr_ok   = g_any && g_write && !err;
  assign set_vec = fire ? (NUM_STREAMS'(1) << nxt_s) : '0;

  always_comb begin
    rd = '0;
    if (is_src)       rd = desc_q.src;
    else if (is_dst)  rd = desc_q.dst;
    else if (is_len)  rd = desc_q.len;
    else if (nxt_hit) rd = 32'(issued_q[nxt_s]);
    else if (dn_hit)  rd = 32'(done_q[dn_s]);
  end

  always_comb begin
    for (int p = 0; p < int'(NUM_PORTS); p++) begin
      pready[p]        = p_gnt[p] && !stall;
      pslverr[p]       = p_gnt[p] && err;
      prdata[p*32 +: 32] = p_gnt[p] ? rd : 32'h0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      desc_q <= '0;
    end else if (wr_ok) begin
      if (is_src) desc_q.src <= merge_bytes(desc_q.src, g_wdata, g_strb);
      if (is_dst) desc_q.dst <= merge_bytes(desc_q.dst, g_wdata, g_strb);
      if (is_len) desc_q.len <= merge_bytes(desc_q.len, g_wdata, g_strb);
    end
  end

  // ---------------- launch slots and backend stage ----------------
  logic [NUM_STREAMS-1:0] s_gnt;
  logic [SW-1:0]          s_sel;
  logic                   s_any, load;

  assign load = !out_v || launch_ready;

  fe_rr_arb #(.N(NUM_STREAMS)) u_slot_arb (
    .clk (clk), .rst (rst), .req (pend_v), .adv (load),
    .gnt (s_gnt), .sel (s_sel), .any (s_any)
  );

  always_ff @(posedge clk) begin
    if (rst) pend_v <= '0;
    else     pend_v <= (pend_v & ~(load ? s_gnt : '0)) | set_vec;
  end

  always_ff @(posedge clk) begin
    if (fire) begin
      pend_d[nxt_s]  <= desc_q;
      pend_id[nxt_s] <= issued_q[nxt_s];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_v  <= 1'b0;
      out_s  <= '0;
      out_d  <= '0;
      out_id <= '0;
    end else if (load) begin
      out_v <= s_any;
      if (s_any) begin
        out_s  <= s_sel;
        out_d  <= pend_d[s_sel];
        out_id <= pend_id[s_sel];
      end
    end
  end

  fe_id_counters #(.NS(NUM_STREAMS), .ID_W(ID_W)) u_cnt (
    .clk (clk), .rst (rst),
    .acc_v (out_v && launch_ready), .acc_s (out_s),
    .cmpl_v (cmpl_valid), .cmpl_s (cmpl_stream),
    .issued_o (issued_q), .done_o (done_q)
  );

  assign launch_valid  = out_v;
  assign launch_stream = out_s;
  assign launch_id     = out_id;
  assign launch_src    = out_d.src;
  assign launch_dst    = out_d.dst;
  assign launch_len    = out_d.len;

endmodule

// File: rtl/dma_launch_fe_chk.sv
module dma_launch_fe_chk
  import dma_launch_pkg::*;
#(
  parameter  int unsigned NUM_PORTS   = 2,
  parameter  int unsigned NUM_STREAMS = 4,
  parameter  int unsigned ID_W        = 32,
  localparam int unsigned SW = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1
) (
  input logic                               clk,
  input logic                               rst,
  input logic [NUM_PORTS-1:0]               psel,
  input logic [NUM_PORTS-1:0]               penable,
  input logic [NUM_PORTS-1:0]               pwrite,
  input logic [NUM_PORTS*32-1:0]            paddr,
  input logic [NUM_PORTS-1:0]               pready,
  input logic [NUM_PORTS-1:0]               pslverr,
  input logic                               launch_valid,
  input logic                               launch_ready,
  input logic [SW-1:0]                      launch_stream,
  input logic [ID_W-1:0]                    launch_id,
  input logic [31:0]                        launch_src,
  input logic [31:0]                        launch_dst,
  input logic [31:0]                        launch_len,
  input logic [NUM_STREAMS-1:0][ID_W-1:0]   issued_q,
  input logic [NUM_STREAMS-1:0][ID_W-1:0]   done_q,
  input logic [NUM_STREAMS-1:0]             busy
);

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (launch_valid && !launch_ready) |=> (launch_valid &&
      $stable({launch_stream, launch_id, launch_src, launch_dst, launch_len})));

  assert_one_port_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pready));

  assert_err_on_done_R9: assert property (@(posedge clk) disable iff (rst)
    (|pslverr) |-> ((pready & pslverr) == pslverr));

  assert_issue_step_R5: assert property (@(posedge clk) disable iff (rst)
    (launch_valid && launch_ready && (launch_stream == '0)) |=>
      (issued_q[0] == $past(issued_q[0]) + 1'b1));

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_str
    assert_done_behind_R7: assert property (@(posedge clk) disable iff (rst)
      ((issued_q[s] - done_q[s]) != '0));
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [31:0]   off;
    logic          hit;
    logic [SW-1:0] six;
    assign off = paddr[p*32 +: 32] - NEXT_BASE;
    assign hit = (off[31:2] < 30'(NUM_STREAMS)) && (off[1:0] == 2'b00);
    assign six = off[SW+1:2];

    assert_zero_wait_R2: assert property (@(posedge clk) disable iff (rst)
      (psel[p] && penable[p] && !pwrite[p] && hit &&
       ($countones(psel & penable) == 1) && !busy[six]) |-> pready[p]);
  end

endmodule

bind dma_launch_fe dma_launch_fe_chk #(
  .NUM_PORTS(NUM_PORTS), .NUM_STREAMS(NUM_STREAMS), .ID_W(ID_W)
) u_chk (.*);

// File: tb/tb_dma_launch_fe.sv
module tb_dma_launch_fe;
  localparam int CLK_P = 10;
  localparam int NP    = 2;
  localparam int NS    = 4;
  localparam int IDW   = 4;
  localparam int SW    = 2;

  logic clk, rst;
  logic [NP-1:0]    psel, penable, pwrite, pready, pslverr;
  logic [NP*32-1:0] paddr, pwdata, prdata;
  logic [NP*4-1:0]  pstrb;
  logic             launch_valid, launch_ready, cmpl_valid;
  logic [SW-1:0]    launch_stream, cmpl_stream;
  logic [IDW-1:0]   launch_id;
  logic [31:0]      launch_src, launch_dst, launch_len;

  dma_launch_fe #(.NUM_PORTS(NP), .NUM_STREAMS(NS), .ID_W(IDW)) dut (.*);

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  typedef struct packed {
    logic [7:0]  s;
    logic [7:0]  id;
    logic [31:0] src;
    logic [31:0] dst;
    logic [31:0] len;
  } exp_t;

  exp_t sbq[$];
  int n_chk = 0, n_fail = 0, n_acc = 0, n_push = 0;
  int enext[NS], edone[NS];
  logic [31:0] m_src = 0, m_dst = 0, m_len = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // ---------------- APB driver ----------------
  task automatic apb_xfer(input int p, input bit wr, input logic [31:0] a,
                          input logic [31:0] wd, input logic [3:0] st,
                          output logic [31:0] rd, output bit err, output int waits);
    @(negedge clk);
    psel[p] = 1'b1; penable[p] = 1'b0; pwrite[p] = wr;
    paddr[p*32 +: 32] = a; pwdata[p*32 +: 32] = wd; pstrb[p*4 +: 4] = st;
    @(negedge clk);
    penable[p] = 1'b1;
    waits = 0;
    forever begin
      #(CLK_P/4);
      if (pready[p]) break;
      waits++;
      @(negedge clk);
    end
    rd  = prdata[p*32 +: 32];
    err = pslverr[p];
    @(negedge clk);
    psel[p] = 1'b0; penable[p] = 1'b0;
  endtask

  task automatic wr32(input logic [31:0] a, input logic [31:0] d,
                      input logic [3:0] st, output bit err);
    logic [31:0] rd; int w;
    apb_xfer(0, 1'b1, a, d, st, rd, err, w);
  endtask

  task automatic rd32(input int p, input logic [31:0] a,
                      output logic [31:0] d, output bit err);
    int w;
    apb_xfer(p, 1'b0, a, 32'h0, 4'h0, d, err, w);
  endtask

  // launch read: pushes the expected backend item and checks the id
  task automatic read_next(input int p, input int s, input string tag,
                           output logic [31:0] id, output int w);
    bit err;
    exp_t e;
    apb_xfer(p, 1'b0, 32'h100 + 32'(4*s), 32'h0, 4'h0, id, err, w);
    chk(!err, tag, "launch read error flag", 32'(err), 0);
    e.s = 8'(s); e.id = id[7:0]; e.src = m_src; e.dst = m_dst; e.len = m_len;
    sbq.push_back(e);
    n_push++;
    chk(id == 32'(enext[s]), tag, "returned identifier", id, 32'(enext[s]));
    enext[s] = (enext[s] + 1) & ((1 << IDW) - 1);
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 100 && sbq.size() != 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(sbq.size() == 0, tag, "expected launches left", 32'(sbq.size()), 0);
  endtask

  task automatic complete(input int s);
    @(negedge clk);
    cmpl_valid = 1'b1; cmpl_stream = SW'(s);
    @(negedge clk);
    cmpl_valid = 1'b0;
    if (((enext[s] - edone[s]) & ((1 << IDW) - 1)) != 1)
      edone[s] = (edone[s] + 1) & ((1 << IDW) - 1);
  endtask

  task automatic check_done(input int s, input string tag);
    logic [31:0] d; bit err;
    rd32(0, 32'h200 + 32'(4*s), d, err);
    chk(!err && d == 32'(edone[s]), tag, "finished register", d, 32'(edone[s]));
  endtask

  // ---------------- monitor / scoreboard ----------------
  initial begin
    logic pv, pr;
    logic [95:0] ppl;
    logic [7:0]  ps, pid;
    pv = 0; pr = 0; ppl = '0; ps = 0; pid = 0;
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      if (rst) begin
        pv = 0; pr = 0;
      end else begin
        if (pv && !pr) begin
          chk(launch_valid, "R4", "valid dropped before ready", 32'(launch_valid), 1);
          chk({launch_src, launch_dst, launch_len} == ppl &&
              8'(launch_stream) == ps && 8'(launch_id) == pid,
              "R4", "payload changed while held", launch_src, ppl[95:64]);
        end
        if (launch_valid && launch_ready) begin
          int hit = -1;
          for (int i = 0; i < sbq.size(); i++)
            if (hit < 0 && sbq[i].s == 8'(launch_stream)) hit = i;
          chk(hit >= 0, "R3", "unexpected launch on stream", 32'(launch_stream), 0);
          if (hit >= 0) begin
            chk(sbq[hit].id == 8'(launch_id), "R3", "launch id", 32'(launch_id), 32'(sbq[hit].id));
            chk({sbq[hit].src, sbq[hit].dst, sbq[hit].len} ==
                {launch_src, launch_dst, launch_len},
                "R3", "launch descriptor src", launch_src, sbq[hit].src);
            sbq.delete(hit);
          end
          n_acc++;
        end
        pv = launch_valid; pr = launch_ready;
        ppl = {launch_src, launch_dst, launch_len};
        ps = 8'(launch_stream); pid = 8'(launch_id);
      end
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run hung actual=%0d expected=%0d", 20000, 0);
    finish_up();
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] d, id, id2;
    bit err;
    int w, w2;
    psel = '0; penable = '0; pwrite = '0; paddr = '0; pwdata = '0; pstrb = '0;
    launch_ready = 1'b0; cmpl_valid = 1'b0; cmpl_stream = '0;
    for (int s = 0; s < NS; s++) begin enext[s] = 2; edone[s] = 1; end
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    #(CLK_P/4);
    chk(!launch_valid, "R1", "launch_valid after reset", 32'(launch_valid), 0);
    for (int s = 0; s < NS; s++) check_done(s, "R1");

    // R8: descriptor writes with byte lanes
    wr32(32'h0, 32'h1122_3344, 4'hF, err);
    wr32(32'h4, 32'hAABB_CCDD, 4'hF, err);
    wr32(32'h8, 32'hFFFF_0100, 4'b0011, err);
    wr32(32'h8, 32'h0055_FFFF, 4'b0100, err);
    m_src = 32'h1122_3344; m_dst = 32'hAABB_CCDD; m_len = 32'h0055_0100;
    rd32(0, 32'h0, d, err); chk(d == m_src, "R8", "src readback", d, m_src);
    rd32(0, 32'h4, d, err); chk(d == m_dst, "R8", "dst readback", d, m_dst);
    rd32(1, 32'h8, d, err); chk(d == m_len, "R8", "len lanes readback", d, m_len);

    // R9: error responses, no side effects
    rd32(0, 32'h300, d, err); chk(err, "R9", "unmapped read error", 32'(err), 1);
    wr32(32'h102, 32'h0, 4'hF, err); chk(err, "R9", "misaligned write error", 32'(err), 1);
    wr32(32'h100, 32'h0, 4'hF, err); chk(err, "R9", "write to launch reg error", 32'(err), 1);
    wr32(32'h0C, 32'hDEAD_BEEF, 4'hF, err); chk(err, "R9", "unmapped write error", 32'(err), 1);
    rd32(0, 32'h0, d, err); chk(d == m_src, "R9", "src untouched", d, m_src);
    rd32(0, 32'h8, d, err); chk(d == m_len, "R9", "len untouched", d, m_len);
    repeat (3) @(negedge clk);
    #(CLK_P/4);
    chk(!launch_valid, "R9", "no launch from bad write", 32'(launch_valid), 0);

    // R2/R3/R4: zero-wait launch under backpressure, held request
    read_next(0, 0, "R2", id, w);
    chk(w == 0, "R2", "wait states with ready low", 32'(w), 0);
    wr32(32'h0, 32'h0000_5000, 4'hF, err); m_src = 32'h0000_5000;
    read_next(1, 2, "R2", id, w);
    chk(w == 0, "R2", "second stream wait states", 32'(w), 0);
    repeat (6) @(negedge clk);
    #(CLK_P/4);
    chk(launch_valid && launch_stream == 0, "R4", "held request stream",
        32'(launch_stream), 0);

    // R6: collision on stream 0 while its launch is held
    fork
      read_next(0, 0, "R6", id2, w2);
      begin repeat (6) @(negedge clk); launch_ready = 1'b1; end
    join
    chk(w2 >= 5, "R6", "stall length", 32'(w2), 5);
    drain("R6");

    // R5: consecutive identifiers
    read_next(0, 3, "R5", id, w); drain("R5");
    read_next(0, 3, "R5", id, w); drain("R5");
    read_next(1, 3, "R5", id, w); drain("R5");

    // R7: completion tracking, spurious completions ignored
    complete(0); check_done(0, "R7");
    complete(0); check_done(0, "R7");
    complete(0); check_done(0, "R7");
    complete(1); check_done(1, "R7");

    // R10: two ports at once
    fork
      read_next(0, 1, "R10", id, w);
      read_next(1, 3, "R10", id2, w2);
    join
    chk(w + w2 == 1, "R10", "total wait states of two ports", 32'(w + w2), 1);
    drain("R10");

    // R11: wrap of the identifier counter on stream 2
    complete(2);
    for (int k = 0; k < 17; k++) begin
      read_next(0, 2, "R11", id, w);
      drain("R11");
      complete(2);
      check_done(2, "R11");
    end

    chk(n_acc == n_push, "R3", "launches accepted vs reads", 32'(n_acc), 32'(n_push));
    finish_up();
  end

endmodule